// File: doc/BRIEF.md
# Serial flash identification probe

This block works out which density variant of a paged serial flash sits on the bus. It then presents that part's geometry: page count, page size in bytes and the address shift that places the page number above the byte offset. It does not shift serial bits itself. It issues one byte at a time to an external byte shifter and receives one byte back per handshake. It frames each command by marking the byte after which chip select must be released.

A probe runs once on its own after reset, and again whenever `probe_req` is seen while the block is idle. First the probe reads the three-byte manufacturer and device ID. When the manufacturer byte is the expected one, the device bytes are looked up in a built-in table. Some entries belong to parts that can be configured for either power-of-two or padded page sizes. For those, a status read follows, and status bit 0 picks the geometry. When the manufacturer byte is anything else, the probe reads status instead and decodes the density code in its middle bits. The outcome is a held geometry with a valid flag, or a held error code.

Top module: `flashid_probe`

## Requirements
- R1: While `rst_n` is low, `xfer_req`, `busy`, `geo_valid` and `err_valid` are low. On the first cycle after release the probe starts: `busy` rises and the first byte requested is 0x9F. The ID command is four bytes: that opcode, then three fill bytes of 0x00. `xfer_last` is set on the fourth byte only. The bytes received in positions 2, 3 and 4 are the manufacturer byte, the high device byte and the low device byte.
- R2: With manufacturer 0x1F, the device bytes (high, low) map to pages / padded page bytes / shift / switchable as follows. 22 00 gives 512/264/9/yes. 23 00 gives 1024/264/9/yes. 24 00 gives 2048/264/9/yes. 25 00 gives 4096/264/9/yes. 26 00 gives 4096/528/10/yes. 27 00 gives 8192/528/10/no. 27 01 gives 8192/528/10/yes. 28 00 gives 8192/1056/11/yes. A part that is not switchable completes after the ID command alone, with that geometry and `geo_rev` = 1.
- R3: For a switchable part, a status command follows: opcode 0xD7, then one fill byte, with `xfer_last` on the second byte. If the returned status has bit 0 set, the page size is 2^(shift-1) and the reported shift is one less than the table shift. If bit 0 is clear, the table geometry is reported. In both cases `geo_rev` = 2.
- R4: A manufacturer byte of 0x1F with device bytes that are not in the table gives `err_valid` with `err_code` = 1. No status command is issued.
- R5: Any other manufacturer byte causes a status command instead. A status value of 0x00 or 0xFF gives `err_code` = 2, meaning no device present.
- R6: In that fallback, the density code is status bits 5:2. Codes 3, 5, 7 and 9 give 512, 1024, 2048 and 4096 pages of 264 bytes, shift 9. Code 11 gives 4096 pages and code 13 gives 8192 pages, both of 528 bytes, shift 10. Codes 14 and 15 give 8192 pages of 1056 bytes, shift 11. `geo_rev` = 0, and status bits 7:6 and 1:0 have no effect on the result.
- R7: Any other fallback code gives `err_code` = 3.
- R8: Geometry and error outputs hold unchanged until a new probe starts. A `probe_req` seen while idle makes `busy` high and `geo_valid` and `err_valid` low on the next cycle. A `probe_req` while busy is ignored.
- R9: `xfer_req` stays high, with `xfer_tx` and `xfer_last` stable, until `xfer_done` is seen. Each `xfer_done` retires exactly one byte.
- R10: `geo_valid` and `err_valid` are never high together, and `busy` is low whenever either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_req | input | 1 | Start a new probe when idle |
| xfer_req | output | 1 | Byte transfer requested from the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_last | output | 1 | Release chip select after this byte |
| xfer_done | input | 1 | One-cycle pulse: byte exchanged |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| busy | output | 1 | Probe in progress |
| geo_valid | output | 1 | Geometry outputs valid |
| geo_pages | output | 14 | Number of pages |
| geo_bytes | output | 11 | Bytes per page |
| geo_shift | output | 4 | Page-number shift in the flash address |
| geo_rev | output | 2 | 0 status-code path, 1 ID without size switch, 2 ID with size switch |
| err_valid | output | 1 | Probe ended in error |
| err_code | output | 2 | 1 unknown ID, 2 no device, 3 unsupported density code |

## Verification
Several properties are checked on every cycle. Valid and error are never high together, and busy is low while either is high. A pending byte request holds steady until its handshake. A new probe opens with the ID opcode. A probe request made while idle clears the results. A held geometry never changes, and its byte count is always either a power of two or the padded size that matches its shift. The remaining checks need scenarios. Each table entry is tried with both values of the status bit, several unknown IDs are tried, and all 256 status values are swept through the fallback decode. Together these show that the right geometry and the right number of commands come out, that a request during a probe does not restart it, and that stray status bits are ignored.

// File: rtl/flashid_pkg.sv
// Shared types and lookup tables for the flash identification probe.
// Assumes table entries always carry a shift of at least 6.
package flashid_pkg;

    typedef enum logic [1:0] {
        FERR_NONE   = 2'd0,
        FERR_NODEV  = 2'd1,
        FERR_ABSENT = 2'd2,
        FERR_UNSUP  = 2'd3
    } ferr_e;

    typedef enum logic [1:0] {
        FREV_CODE   = 2'd0,
        FREV_FIXED  = 2'd1,
        FREV_SWITCH = 2'd2
    } frev_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_IDCMD,
        PS_IDEVAL,
        PS_STCMD,
        PS_STEVAL
    } pstate_e;

    // hit: entry found; pow2: size switchable; plog2: log2 of page count;
    // shift: page shift for the padded page size
    typedef struct packed {
        logic       hit;
        logic       pow2;
        logic [3:0] plog2;
        logic [3:0] shift;
    } geo_ent_t;

    // Device-byte lookup for the ID path
    function automatic geo_ent_t id_lookup(input logic [7:0] dev_hi,
                                           input logic [7:0] dev_lo);
        geo_ent_t e;
        e = '0;
        case ({dev_hi, dev_lo})
            16'h2200: e = '{hit: 1'b1, pow2: 1'b1, plog2: 4'd9,  shift: 4'd9};
            16'h2300: e = '{hit: 1'b1, pow2: 1'b1, plog2: 4'd10, shift: 4'd9};
            16'h2400: e = '{hit: 1'b1, pow2: 1'b1, plog2: 4'd11, shift: 4'd9};
            16'h2500: e = '{hit: 1'b1, pow2: 1'b1, plog2: 4'd12, shift: 4'd9};
            16'h2600: e = '{hit: 1'b1, pow2: 1'b1, plog2: 4'd12, shift: 4'd10};
            16'h2700: e = '{hit: 1'b1, pow2: 1'b0, plog2: 4'd13, shift: 4'd10};
            16'h2701: e = '{hit: 1'b1, pow2: 1'b1, plog2: 4'd13, shift: 4'd10};
            16'h2800: e = '{hit: 1'b1, pow2: 1'b1, plog2: 4'd13, shift: 4'd11};
            default:  e = '0;
        endcase
        return e;
    endfunction

    // Density-code lookup for the status fallback path (status bits 5:2)
    function automatic geo_ent_t code_lookup(input logic [3:0] code);
        geo_ent_t e;
        e = '0;
        case (code)
            4'd3:    e = '{hit: 1'b1, pow2: 1'b0, plog2: 4'd9,  shift: 4'd9};
            4'd5:    e = '{hit: 1'b1, pow2: 1'b0, plog2: 4'd10, shift: 4'd9};
            4'd7:    e = '{hit: 1'b1, pow2: 1'b0, plog2: 4'd11, shift: 4'd9};
            4'd9:    e = '{hit: 1'b1, pow2: 1'b0, plog2: 4'd12, shift: 4'd9};
            4'd11:   e = '{hit: 1'b1, pow2: 1'b0, plog2: 4'd12, shift: 4'd10};
            4'd13:   e = '{hit: 1'b1, pow2: 1'b0, plog2: 4'd13, shift: 4'd10};
            4'd14,
            4'd15:   e = '{hit: 1'b1, pow2: 1'b0, plog2: 4'd13, shift: 4'd11};
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/flashid_decode.sv
// Combinational geometry lookup for both probe paths.
// Assumes its inputs come from registers held by the sequencer.
module flashid_decode
    import flashid_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CODE_LO = 2,
    parameter int CODE_W = 4
) (
    input  logic [BYTE_W-1:0] dev_hi,
    input  logic [BYTE_W-1:0] dev_lo,
    input  logic [CODE_W-1:0] dens_code,
    output geo_ent_t          id_ent,
    output geo_ent_t          fb_ent
);

    // Table lookups, one per path
    always_comb begin
        id_ent = id_lookup(dev_hi[7:0], dev_lo[7:0]);
        fb_ent = code_lookup(dens_code[3:0]);
    end

endmodule

// File: rtl/flashid_seq.sv
// Probe sequencer. It issues the ID command, optionally the status command,
// and decides the outcome. It talks to a byte shifter through a
// request/done handshake and holds each request until its done pulse.
module flashid_seq
    import flashid_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] OP_ID     = 8'h9F,
    parameter logic [BYTE_W-1:0] OP_STATUS = 8'hD7,
    parameter logic [BYTE_W-1:0] MFR_CODE  = 8'h1F,
    parameter logic [BYTE_W-1:0] FILL      = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_req,
    output logic              xfer_req,
    output logic [BYTE_W-1:0] xfer_tx,
    output logic              xfer_last,
    input  logic              xfer_done,
    input  logic [BYTE_W-1:0] xfer_rx,
    output logic [BYTE_W-1:0] dev_hi,
    output logic [BYTE_W-1:0] dev_lo,
    output logic [BYTE_W-1:0] stat,
    input  geo_ent_t          id_ent,
    input  geo_ent_t          fb_ent,
    output logic              busy,
    output logic              res_clear,
    output logic              res_load,
    output logic [3:0]        res_plog2,
    output logic [3:0]        res_shift,
    output logic              res_bin,
    output frev_e             res_rev,
    output logic              res_err,
    output ferr_e             res_code
);

    localparam int ID_LEN = 4;
    localparam int ST_LEN = 2;
    localparam int IDX_W  = $clog2(ID_LEN);
    localparam logic [IDX_W-1:0] ID_END = IDX_W'(ID_LEN - 1);
    localparam logic [IDX_W-1:0] ST_END = IDX_W'(ST_LEN - 1);
    localparam logic [BYTE_W-1:0] ALL_ONES = '1;

    pstate_e           state;
    logic [IDX_W-1:0]  bidx;
    logic              pend;
    logic              fb_mode;
    logic [BYTE_W-1:0] mfr_q;
    logic              start;

    assign start = (state == PS_IDLE) && (pend || probe_req);

    // State, byte index and captured response bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PS_IDLE;
            bidx    <= '0;
            pend    <= 1'b1;
            fb_mode <= 1'b0;
            mfr_q   <= '0;
            dev_hi  <= '0;
            dev_lo  <= '0;
            stat    <= '0;
        end else begin
            case (state)
                PS_IDLE: begin
                    if (start) begin
                        state <= PS_IDCMD;
                        bidx  <= '0;
                        pend  <= 1'b0;
                    end
                end
                PS_IDCMD: begin
                    if (xfer_done) begin
                        case (bidx)
                            IDX_W'(1): mfr_q  <= xfer_rx;
                            IDX_W'(2): dev_hi <= xfer_rx;
                            IDX_W'(3): dev_lo <= xfer_rx;
                            default:   ;
                        endcase
                        if (bidx == ID_END) begin
                            state <= PS_IDEVAL;
                            bidx  <= '0;
                        end else begin
                            bidx <= bidx + IDX_W'(1);
                        end
                    end
                end
                PS_IDEVAL: begin
                    if (mfr_q != MFR_CODE) begin
                        fb_mode <= 1'b1;
                        state   <= PS_STCMD;
                    end else if (id_ent.hit && id_ent.pow2) begin
                        fb_mode <= 1'b0;
                        state   <= PS_STCMD;
                    end else begin
                        state <= PS_IDLE;
                    end
                end
                PS_STCMD: begin
                    if (xfer_done) begin
                        if (bidx == ST_END) begin
                            stat  <= xfer_rx;
                            state <= PS_STEVAL;
                            bidx  <= '0;
                        end else begin
                            bidx <= bidx + IDX_W'(1);
                        end
                    end
                end
                PS_STEVAL: state <= PS_IDLE;
                default:   state <= PS_IDLE;
            endcase
        end
    end

    // Byte request toward the shifter
    always_comb begin
        xfer_req  = (state == PS_IDCMD) || (state == PS_STCMD);
        if (bidx == '0) begin
            xfer_tx = (state == PS_STCMD) ? OP_STATUS : OP_ID;
        end else begin
            xfer_tx = FILL;
        end
        xfer_last = ((state == PS_IDCMD) && (bidx == ID_END)) ||
                    ((state == PS_STCMD) && (bidx == ST_END));
        busy      = (state != PS_IDLE);
        res_clear = start;
    end

    // Outcome of the probe, produced in the evaluation states
    always_comb begin
        res_load  = 1'b0;
        res_plog2 = '0;
        res_shift = '0;
        res_bin   = 1'b0;
        res_rev   = FREV_CODE;
        res_err   = 1'b0;
        res_code  = FERR_NONE;
        if (state == PS_IDEVAL && mfr_q == MFR_CODE) begin
            if (!id_ent.hit) begin
                res_err  = 1'b1;
                res_code = FERR_NODEV;
            end else if (!id_ent.pow2) begin
                res_load  = 1'b1;
                res_plog2 = id_ent.plog2;
                res_shift = id_ent.shift;
                res_rev   = FREV_FIXED;
            end
        end else if (state == PS_STEVAL) begin
            if (fb_mode) begin
                if (stat == '0 || stat == ALL_ONES) begin
                    res_err  = 1'b1;
                    res_code = FERR_ABSENT;
                end else if (fb_ent.hit) begin
                    res_load  = 1'b1;
                    res_plog2 = fb_ent.plog2;
                    res_shift = fb_ent.shift;
                    res_bin   = fb_ent.pow2;
                    res_rev   = FREV_CODE;
                end else begin
                    res_err  = 1'b1;
                    res_code = FERR_UNSUP;
                end
            end else begin
                res_load  = 1'b1;
                res_plog2 = id_ent.plog2;
                res_shift = id_ent.shift;
                res_bin   = stat[0];
                res_rev   = FREV_SWITCH;
            end
        end
    end

endmodule

// File: rtl/flashid_result.sv
// Result holding registers. They turn a table entry into page count,
// page size and shift, and hold it (or an error code) until cleared.
// Assumes load, err and clear are never high together.
module flashid_result
    import flashid_pkg::*;
#(
    parameter int PAGES_W = 14,
    parameter int BYTES_W = 11,
    parameter int SHIFT_W = 4,
    parameter int PAD_GAP = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic [3:0]         plog2,
    input  logic [3:0]         shift,
    input  logic               binary,
    input  frev_e              rev,
    input  logic               err,
    input  ferr_e              code,
    output logic               geo_valid,
    output logic [PAGES_W-1:0] geo_pages,
    output logic [BYTES_W-1:0] geo_bytes,
    output logic [SHIFT_W-1:0] geo_shift,
    output logic [1:0]         geo_rev,
    output logic               err_valid,
    output logic [1:0]         err_code
);

    logic [SHIFT_W-1:0] sh_full;
    logic [SHIFT_W-1:0] sh_bin;
    logic [BYTES_W-1:0] base_bytes;
    logic [BYTES_W-1:0] pad_bytes;

    // Page size: a power of two, plus a padding term for the padded layout
    always_comb begin
        sh_full    = SHIFT_W'(shift);
        sh_bin     = sh_full - SHIFT_W'(1);
        base_bytes = BYTES_W'(1) << sh_bin;
        pad_bytes  = BYTES_W'(1) << (sh_bin - SHIFT_W'(PAD_GAP));
    end

    // Hold the outcome until the next probe starts
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            geo_valid <= 1'b0;
            geo_pages <= '0;
            geo_bytes <= '0;
            geo_shift <= '0;
            geo_rev   <= '0;
            err_valid <= 1'b0;
            err_code  <= '0;
        end else if (load) begin
            geo_valid <= 1'b1;
            geo_pages <= PAGES_W'(1) << plog2;
            geo_bytes <= binary ? base_bytes : (base_bytes + pad_bytes);
            geo_shift <= binary ? sh_bin : sh_full;
            geo_rev   <= rev;
        end else if (err) begin
            err_valid <= 1'b1;
            err_code  <= code;
        end
    end

endmodule

// File: rtl/flashid_probe.sv
// Top of the flash identification probe: sequencer, table lookup and
// result registers. It drives an external byte shifter; see the brief.
module flashid_probe
    import flashid_pkg::*;
#(
    parameter int PAGES_W = 14,
    parameter int BYTES_W = 11,
    parameter int SHIFT_W = 4,
    parameter logic [7:0] OP_ID     = 8'h9F,
    parameter logic [7:0] OP_STATUS = 8'hD7,
    parameter logic [7:0] MFR_CODE  = 8'h1F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               probe_req,
    output logic               xfer_req,
    output logic [7:0]         xfer_tx,
    output logic               xfer_last,
    input  logic               xfer_done,
    input  logic [7:0]         xfer_rx,
    output logic               busy,
    output logic               geo_valid,
    output logic [PAGES_W-1:0] geo_pages,
    output logic [BYTES_W-1:0] geo_bytes,
    output logic [SHIFT_W-1:0] geo_shift,
    output logic [1:0]         geo_rev,
    output logic               err_valid,
    output logic [1:0]         err_code
);

    localparam int BYTE_W  = 8;
    localparam int CODE_LO = 2;
    localparam int CODE_W  = 4;

    logic [BYTE_W-1:0] dev_hi, dev_lo, stat;
    geo_ent_t          id_ent, fb_ent;
    logic              res_clear, res_load, res_bin, res_err;
    logic [3:0]        res_plog2, res_shift;
    frev_e             res_rev;
    ferr_e             res_code;

    flashid_seq #(
        .BYTE_W(BYTE_W), .OP_ID(OP_ID), .OP_STATUS(OP_STATUS),
        .MFR_CODE(MFR_CODE), .FILL(8'h00)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .probe_req(probe_req),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_last(xfer_last),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx),
        .dev_hi(dev_hi), .dev_lo(dev_lo), .stat(stat),
        .id_ent(id_ent), .fb_ent(fb_ent), .busy(busy),
        .res_clear(res_clear), .res_load(res_load),
        .res_plog2(res_plog2), .res_shift(res_shift), .res_bin(res_bin),
        .res_rev(res_rev), .res_err(res_err), .res_code(res_code)
    );

    flashid_decode #(
        .BYTE_W(BYTE_W), .CODE_LO(CODE_LO), .CODE_W(CODE_W)
    ) u_dec (
        .dev_hi(dev_hi), .dev_lo(dev_lo),
        .dens_code(stat[CODE_LO +: CODE_W]),
        .id_ent(id_ent), .fb_ent(fb_ent)
    );

    flashid_result #(
        .PAGES_W(PAGES_W), .BYTES_W(BYTES_W), .SHIFT_W(SHIFT_W), .PAD_GAP(5)
    ) u_res (
        .clk(clk), .rst_n(rst_n), .clear(res_clear), .load(res_load),
        .plog2(res_plog2), .shift(res_shift), .binary(res_bin),
        .rev(res_rev), .err(res_err), .code(res_code),
        .geo_valid(geo_valid), .geo_pages(geo_pages), .geo_bytes(geo_bytes),
        .geo_shift(geo_shift), .geo_rev(geo_rev),
        .err_valid(err_valid), .err_code(err_code)
    );

endmodule

// File: rtl/flashid_probe_chk.sv
// Cycle-by-cycle checks on the probe's ports, bound to the top module.
module flashid_probe_chk #(
    parameter int PAGES_W = 14,
    parameter int BYTES_W = 11,
    parameter int SHIFT_W = 4,
    parameter logic [7:0] OP_ID     = 8'h9F,
    parameter logic [7:0] OP_STATUS = 8'hD7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               probe_req,
    input logic               xfer_req,
    input logic [7:0]         xfer_tx,
    input logic               xfer_last,
    input logic               xfer_done,
    input logic               busy,
    input logic               geo_valid,
    input logic [PAGES_W-1:0] geo_pages,
    input logic [BYTES_W-1:0] geo_bytes,
    input logic [SHIFT_W-1:0] geo_shift,
    input logic [1:0]         geo_rev,
    input logic               err_valid,
    input logic [1:0]         err_code
);

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(geo_valid && err_valid));

    // R10
    idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (geo_valid || err_valid) |-> !busy);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx) && $stable(xfer_last)));

    // R1
    start_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (xfer_req && xfer_tx == OP_ID));

    // R1
    cmd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> (xfer_tx == OP_ID || xfer_tx == OP_STATUS));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && !busy) |=> (busy && !geo_valid && !err_valid));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (geo_valid && $past(geo_valid)) |->
        ($stable(geo_pages) && $stable(geo_bytes) && $stable(geo_shift) && $stable(geo_rev)));

    // R3
    shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        geo_valid |-> ((32'(geo_bytes) == (32'd1 << geo_shift)) ||
                       (32'(geo_bytes) == ((32'd1 << (32'(geo_shift) - 32'd1)) +
                                           (32'd1 << (32'(geo_shift) - 32'd6))))));

    // R4
    code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code != 2'd0));

endmodule

bind flashid_probe flashid_probe_chk #(
    .PAGES_W(PAGES_W), .BYTES_W(BYTES_W), .SHIFT_W(SHIFT_W),
    .OP_ID(OP_ID), .OP_STATUS(OP_STATUS)
) u_chk (.*);

// File: tb/sim_flashid_probe.sv
module sim_flashid_probe;
    localparam int CLK_PERIOD = 10;
    localparam int PAGES_W = 14;
    localparam int BYTES_W = 11;
    localparam int SHIFT_W = 4;
    localparam int LOG_N = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic probe_req = 1'b0;
    logic xfer_req, xfer_last;
    logic [7:0] xfer_tx;
    logic xfer_done = 1'b0;
    logic [7:0] xfer_rx = 8'h00;
    logic busy, geo_valid, err_valid;
    logic [PAGES_W-1:0] geo_pages;
    logic [BYTES_W-1:0] geo_bytes;
    logic [SHIFT_W-1:0] geo_shift;
    logic [1:0] geo_rev, err_code;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flashid_probe u0 (
        .clk(clk), .rst_n(rst_n), .probe_req(probe_req),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_last(xfer_last),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx), .busy(busy),
        .geo_valid(geo_valid), .geo_pages(geo_pages), .geo_bytes(geo_bytes),
        .geo_shift(geo_shift), .geo_rev(geo_rev),
        .err_valid(err_valid), .err_code(err_code)
    );

    // Flash model: settings written by the stimulus only
    logic [7:0] m_id0 = 8'h1F, m_id1 = 8'h27, m_id2 = 8'h00, m_st = 8'h00;
    int m_lat = 1;
    // Model state: written by the model process only
    logic m_act = 1'b0, m_fin = 1'b0, m_last = 1'b0;
    logic [7:0] m_byte = 8'h00, m_op = 8'h00;
    int m_pos = 0, m_cnt = 0, m_ncmd = 0, m_r9bad = 0;
    logic [7:0] m_ops [0:LOG_N-1];
    int m_lens [0:LOG_N-1];

    function automatic logic [7:0] resp(input logic [7:0] op, input int pos);
        if (op == 8'h9F) begin
            if (pos == 1) return m_id0;
            if (pos == 2) return m_id1;
            if (pos == 3) return m_id2;
        end else if (op == 8'hD7 && pos == 1) begin
            return m_st;
        end
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (!rst_n) begin
            m_act = 1'b0; m_fin = 1'b0; m_pos = 0;
        end else if (m_fin) begin
            m_fin = 1'b0; m_act = 1'b0;
        end else if (m_act) begin
            if (!xfer_req || xfer_tx != m_byte || xfer_last != m_last) m_r9bad++;
            if (m_cnt == 0) begin
                xfer_done <= 1'b1;
                xfer_rx   <= resp(m_op, m_pos);
                m_fin = 1'b1;
                if (m_last) begin
                    if (m_ncmd > 0 && m_ncmd <= LOG_N) m_lens[m_ncmd-1] = m_pos + 1;
                    m_pos = 0;
                end else begin
                    m_pos++;
                end
            end else begin
                m_cnt--;
            end
        end else if (xfer_req) begin
            m_act = 1'b1; m_byte = xfer_tx; m_last = xfer_last; m_cnt = m_lat;
            if (m_pos == 0) begin
                m_op = xfer_tx;
                if (m_ncmd < LOG_N) m_ops[m_ncmd] = xfer_tx;
                m_ncmd++;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_end();
        int k;
        k = 0;
        while (busy || !(geo_valid || err_valid)) begin
            @(negedge clk);
            k++;
            if (k > 3000) begin
                n_tests++; n_fail++;
                $display("FAIL R10 probe end: actual busy=%0d expected 0", busy);
                return;
            end
        end
    endtask

    task automatic start_probe();
        @(negedge clk);
        probe_req = 1'b1;
        @(negedge clk);
        probe_req = 1'b0;
        chk("R8", "busy after request", int'(busy), 1);
        chk("R8", "valid cleared", int'(geo_valid), 0);
        chk("R8", "error cleared", int'(err_valid), 0);
    endtask

    // Command framing since index base: R1 for the ID command, R3 for status
    task automatic chk_frames(input int base, input int ncmds);
        chk("R1", "command count", m_ncmd - base, ncmds);
        chk("R1", "first opcode", int'(m_ops[base]), 'h9F);
        chk("R1", "ID command length", m_lens[base], 4);
        if (ncmds == 2) begin
            chk("R3", "second opcode", int'(m_ops[base+1]), 'hD7);
            chk("R3", "status command length", m_lens[base+1], 2);
        end
    endtask

    task automatic chk_geo(input string tag, input int pages, input int bytes,
                           input int shift, input int rev);
        chk(tag, "geo_valid", int'(geo_valid), 1);
        chk("R10", "err_valid", int'(err_valid), 0);
        chk("R10", "busy", int'(busy), 0);
        chk(tag, "pages", int'(geo_pages), pages);
        chk(tag, "bytes", int'(geo_bytes), bytes);
        chk(tag, "shift", int'(geo_shift), shift);
        chk(tag, "rev", int'(geo_rev), rev);
    endtask

    task automatic chk_err(input string tag, input int code);
        chk(tag, "err_valid", int'(err_valid), 1);
        chk("R10", "geo_valid", int'(geo_valid), 0);
        chk(tag, "err_code", int'(err_code), code);
    endtask

    function automatic int pad_bytes(input int sh);
        return (1 << (sh - 1)) + (1 << (sh - 6));
    endfunction

    // R2 table: device bytes, log2 pages, padded shift, switchable
    task automatic id_entry(input int i, output logic [7:0] hi, output logic [7:0] lo,
                            output int plog2, output int sh, output bit sw);
        lo = 8'h00; sw = 1'b1;
        case (i)
            0: begin hi = 8'h22; plog2 = 9;  sh = 9;  end
            1: begin hi = 8'h23; plog2 = 10; sh = 9;  end
            2: begin hi = 8'h24; plog2 = 11; sh = 9;  end
            3: begin hi = 8'h25; plog2 = 12; sh = 9;  end
            4: begin hi = 8'h26; plog2 = 12; sh = 10; end
            5: begin hi = 8'h27; plog2 = 13; sh = 10; sw = 1'b0; end
            6: begin hi = 8'h27; lo = 8'h01; plog2 = 13; sh = 10; end
            default: begin hi = 8'h28; plog2 = 13; sh = 11; end
        endcase
    endtask

    initial begin
        int base;
        logic [7:0] hi, lo;
        int plog2, sh, kind, code;
        bit sw;
        logic [PAGES_W-1:0] s_pages;
        logic [BYTES_W-1:0] s_bytes;

        // R1 reset state
        repeat (4) @(negedge clk);
        chk("R1", "xfer_req in reset", int'(xfer_req), 0);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "geo_valid in reset", int'(geo_valid), 0);
        chk("R1", "err_valid in reset", int'(err_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 1);
        chk("R1", "first byte", int'(xfer_tx), 'h9F);
        wait_end();
        chk_frames(0, 1);
        chk_geo("R2", 8192, 528, 10, 1);

        // R8 hold while idle, even as the attached part changes
        s_pages = geo_pages; s_bytes = geo_bytes;
        m_id1 = 8'h22; m_st = 8'h3D;
        repeat (25) @(negedge clk);
        chk("R8", "pages held", int'(geo_pages), int'(s_pages));
        chk("R8", "bytes held", int'(geo_bytes), int'(s_bytes));
        chk("R8", "valid held", int'(geo_valid), 1);

        // R2/R3 sweep over every table entry and both size-select values
        for (int i = 0; i < 8; i++) begin
            for (int b = 0; b < 2; b++) begin
                id_entry(i, hi, lo, plog2, sh, sw);
                m_id0 = 8'h1F; m_id1 = hi; m_id2 = lo;
                m_st = {7'(i * 19 + 3), 1'(b)};
                m_lat = (i + b) % 3;
                base = m_ncmd;
                start_probe();
                wait_end();
                if (!sw) begin
                    chk_frames(base, 1);
                    chk_geo("R2", 1 << plog2, pad_bytes(sh), sh, 1);
                end else begin
                    chk_frames(base, 2);
                    if (b == 1) chk_geo("R3", 1 << plog2, 1 << (sh - 1), sh - 1, 2);
                    else        chk_geo("R3", 1 << plog2, pad_bytes(sh), sh, 2);
                end
            end
        end

        // R4 unknown device bytes under the right manufacturer
        for (int u = 0; u < 3; u++) begin
            m_id0 = 8'h1F;
            m_id1 = (u == 0) ? 8'h29 : ((u == 1) ? 8'h22 : 8'h00);
            m_id2 = (u == 1) ? 8'h01 : 8'h00;
            m_st = 8'h25;
            base = m_ncmd;
            start_probe();
            wait_end();
            chk_frames(base, 1);
            chk_err("R4", 1);
        end

        // R5/R6/R7 fallback sweep over every status value
        for (int s = 0; s < 256; s++) begin
            m_id0 = (s % 2 == 1) ? 8'h00 : 8'hC2;
            m_id1 = 8'h26; m_id2 = 8'h00;
            m_st = 8'(s);
            m_lat = s % 3;
            base = m_ncmd;
            start_probe();
            wait_end();
            chk_frames(base, 2);
            code = (s >> 2) & 15;
            kind = 0; plog2 = 0; sh = 0;
            if (s == 0 || s == 255) kind = 2;
            else if (code == 3 || code == 5 || code == 7 || code == 9) begin
                plog2 = 9 + (code - 3) / 2; sh = 9;
            end else if (code == 11) begin plog2 = 12; sh = 10; end
            else if (code == 13) begin plog2 = 13; sh = 10; end
            else if (code >= 14) begin plog2 = 13; sh = 11; end
            else kind = 3;
            if (kind == 2) chk_err("R5", 2);
            else if (kind == 3) chk_err("R7", 3);
            else chk_geo("R6", 1 << plog2, pad_bytes(sh), sh, 0);
        end

        // R8 request while busy is ignored (no restart, one probe's commands)
        m_id0 = 8'h1F; m_id1 = 8'h24; m_id2 = 8'h00; m_st = 8'h01; m_lat = 2;
        base = m_ncmd;
        start_probe();
        repeat (3) @(negedge clk);
        probe_req = 1'b1;
        @(negedge clk);
        probe_req = 1'b0;
        wait_end();
        chk("R8", "commands with request during probe", m_ncmd - base, 2);
        chk_geo("R3", 2048, 256, 8, 2);

        // R9 handshake held by the design on every byte
        chk("R9", "request changes before done", m_r9bad, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule